// File: doc/BRIEF.md
# Age-Ordered Deflection Allocator

This block is the decision core of a bufferless router tile in a two-dimensional mesh. In every cycle, up to four flits arrive from the neighbouring links. One more flit may be offered by the local node for injection. The block must send every flit it accepts onward in that same cycle, because it holds nothing back.

Each flit computes the link it would like to use, with the X dimension routed before Y. The flits are ranked by timestamp through a three-stage compare-swap network. Output links are then handed out greedily, from the oldest flit down. A flit whose link is already taken is bounced onto the lowest-numbered link still free. One flit addressed to this node leaves through the ejection output, and the oldest such flit is chosen. A waiting local flit is accepted only when a link would otherwise sit idle, and it ranks below all traffic already in the network.

All results are registered, so they appear one cycle after the inputs that produced them.

Top module: `defl_router_alloc`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_vld` and `ej_vld` are all zero.
- R2: A flit is the concatenation {dst_x, dst_y, age, payload}, with dst_x in the most significant CW bits and payload in the least significant PW bits. Its wanted port code is 2 (east) if dst_x > here_x, else 3 (west) if dst_x < here_x. Failing both, it is 0 (north) if dst_y > here_y, else 1 (south) if dst_y < here_y. Otherwise the flit is addressed to this node.
- R3: A smaller age value is older. On equal ages the lower input index (the slice `in_flit[i*FW +: FW]`) is older. The oldest valid flit that wants a port always receives that port.
- R4: Flits are served from oldest to youngest. Each one gets its wanted port if no older flit holds it, and otherwise gets the lowest-numbered port still free.
- R5: Every valid input flit that is not ejected, and every accepted injection, leaves on exactly one output port in that cycle. No port carries two flits.
- R6: Among valid flits addressed to this node, the oldest is presented on `ej_flit` with `ej_vld` set. Any other such flits have no wanted port and are deflected under R4.
- R7: `inj_ack` is 1 exactly when `inj_vld` is 1 and fewer than four network flits remain after ejection. An accepted injection is served after all network flits.
- R8: Outputs change only at the clock edge. The result of the inputs applied in one cycle appears after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| here_x | input | CW | X coordinate of this node |
| here_y | input | CW | Y coordinate of this node |
| in_vld | input | 4 | Valid bit per incoming link |
| in_flit | input | 4*FW | Incoming flits, link i in bits i*FW +: FW |
| inj_vld | input | 1 | Local flit waiting for injection |
| inj_flit | input | FW | Local flit offered for injection |
| inj_ack | output | 1 | Offered local flit accepted this cycle |
| out_vld | output | 4 | Valid bit per output port (0 N, 1 S, 2 E, 3 W) |
| out_flit | output | 4*FW | Outgoing flits, port p in bits p*FW +: FW |
| ej_vld | output | 1 | A flit is being ejected |
| ej_flit | output | FW | Ejected flit |

## Verification
The hardest case to reach from the ports is one where ejection, injection and deflection all happen at once. All four links must be busy, several flits must share a timestamp and target this node, and one of them must be ejected. That ejection frees the room that lets the injected flit in, which then loses its wanted port and is deflected. The stimulus sweeps every combination of input valid mask and injection request. Destinations are drawn from a three-by-three patch centred on the node, and ages come from only four values. Collisions, ties and local hits therefore occur in most cycles, and directed vectors add the fully loaded tie and ejection cases explicitly.

// File: rtl/defl_pkg.sv
package defl_pkg;
    localparam int NPORT = 4;
    localparam int NSLOT = NPORT + 1;

    typedef enum logic [1:0] {
        PORT_N = 2'd0,
        PORT_S = 2'd1,
        PORT_E = 2'd2,
        PORT_W = 2'd3
    } port_e;
endpackage

// File: rtl/defl_route_calc.sv
module defl_route_calc
    import defl_pkg::*;
#(
    parameter int CW = 3
) (
    input  logic [CW-1:0] here_x,
    input  logic [CW-1:0] here_y,
    input  logic [CW-1:0] dst_x,
    input  logic [CW-1:0] dst_y,
    output logic [1:0]    want,
    output logic          is_local
);
    // X is resolved first, then Y; an exact match means the flit is home
    always_comb begin
        is_local = 1'b0;
        want     = PORT_N;
        if (dst_x > here_x)      want = PORT_E;
        else if (dst_x < here_x) want = PORT_W;
        else if (dst_y > here_y) want = PORT_N;
        else if (dst_y < here_y) want = PORT_S;
        else                     is_local = 1'b1;
    end
endmodule

// File: rtl/defl_age_sort.sv
module defl_age_sort
    import defl_pkg::*;
#(
    parameter  int AW = 4,
    localparam int IW = $clog2(NPORT),
    localparam int KW = 1 + AW + IW
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NPORT-1:0]          vld,
    input  logic [NPORT-1:0][AW-1:0]  age,
    output logic [NPORT-1:0][IW-1:0]  order
);
    // key: invalid flits sink to the end, then age, then input index
    logic [KW-1:0] st0 [NPORT];
    logic [KW-1:0] st1 [NPORT];
    logic [KW-1:0] st2 [NPORT];
    logic [KW-1:0] st3 [NPORT];

    function automatic logic [KW-1:0] kmin(input logic [KW-1:0] a, input logic [KW-1:0] b);
        return (a < b) ? a : b;
    endfunction

    function automatic logic [KW-1:0] kmax(input logic [KW-1:0] a, input logic [KW-1:0] b);
        return (a < b) ? b : a;
    endfunction

    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            st0[i] = {~vld[i], age[i], IW'(i)};
        end
        // stage 1: neighbouring pairs
        st1[0] = kmin(st0[0], st0[1]);
        st1[1] = kmax(st0[0], st0[1]);
        st1[2] = kmin(st0[2], st0[3]);
        st1[3] = kmax(st0[2], st0[3]);
        // stage 2: across the halves
        st2[0] = kmin(st1[0], st1[2]);
        st2[2] = kmax(st1[0], st1[2]);
        st2[1] = kmin(st1[1], st1[3]);
        st2[3] = kmax(st1[1], st1[3]);
        // stage 3: middle pair
        st3[0] = st2[0];
        st3[1] = kmin(st2[1], st2[2]);
        st3[2] = kmax(st2[1], st2[2]);
        st3[3] = st2[3];
        for (int k = 0; k < NPORT; k++) begin
            order[k] = st3[k][IW-1:0];
        end
    end

    logic [NPORT-1:0] seen;
    always_comb begin
        seen = '0;
        for (int k = 0; k < NPORT; k++) seen[order[k]] = 1'b1;
    end

    // R3
    sort_perm_chk: assert property (@(posedge clk) disable iff (!rst_n) seen == {NPORT{1'b1}});

    for (genvar k = 0; k < NPORT - 1; k++) begin : g_ord
        // R3
        sort_rank_chk: assert property (@(posedge clk) disable iff (!rst_n) st3[k] < st3[k+1]);
    end
endmodule

// File: rtl/defl_port_alloc.sv
module defl_port_alloc
    import defl_pkg::*;
#(
    localparam int IW = $clog2(NPORT)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NSLOT-1:0]          s_vld,
    input  logic [NSLOT-1:0][IW-1:0]  s_want,
    input  logic [NSLOT-1:0]          s_pref,
    output logic [NSLOT-1:0][IW-1:0]  s_port
);
    logic [NPORT-1:0] free;
    logic [IW-1:0]    pick;
    logic             found;
    logic             starved;

    // slot 0 is the oldest; each slot sees the ports left by older slots
    always_comb begin
        free    = '1;
        s_port  = '0;
        pick    = '0;
        found   = 1'b0;
        starved = 1'b0;
        for (int s = 0; s < NSLOT; s++) begin
            if (s_vld[s]) begin
                if (s_pref[s] && free[s_want[s]]) begin
                    pick = s_want[s];
                end else begin
                    pick  = '0;
                    found = 1'b0;
                    for (int j = 0; j < NPORT; j++) begin
                        if (!found && free[j]) begin
                            pick  = IW'(j);
                            found = 1'b1;
                        end
                    end
                    starved = starved | ~found;
                end
                free[pick] = 1'b0;
                s_port[s]  = pick;
            end
        end
    end

    // R3
    oldest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_vld[0] && s_pref[0]) |-> s_port[0] == s_want[0]);
    // R5
    no_starve_chk: assert property (@(posedge clk) disable iff (!rst_n) !starved);
    // R5
    port_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~free) == $countones(s_vld));
endmodule

// File: rtl/defl_router_alloc.sv
module defl_router_alloc
    import defl_pkg::*;
#(
    parameter  int CW = 3,
    parameter  int AW = 4,
    parameter  int PW = 8,
    localparam int FW = 2 * CW + AW + PW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CW-1:0]         here_x,
    input  logic [CW-1:0]         here_y,
    input  logic [NPORT-1:0]      in_vld,
    input  logic [NPORT*FW-1:0]   in_flit,
    input  logic                  inj_vld,
    input  logic [FW-1:0]         inj_flit,
    output logic                  inj_ack,
    output logic [NPORT-1:0]      out_vld,
    output logic [NPORT*FW-1:0]   out_flit,
    output logic                  ej_vld,
    output logic [FW-1:0]         ej_flit
);
    localparam int IW = $clog2(NPORT);

    typedef struct packed {
        logic [NPORT-1:0]          ovld;
        logic [NPORT-1:0][FW-1:0]  oflit;
        logic                      ejv;
        logic [FW-1:0]             ejf;
    } state_t;

    state_t d, q;

    logic [NSLOT-1:0][FW-1:0]  src_flit;
    logic [NSLOT-1:0][1:0]     want;
    logic [NSLOT-1:0]          loc;
    logic [NPORT-1:0][AW-1:0]  age_vec;
    logic [NPORT-1:0][IW-1:0]  ord;

    for (genvar gi = 0; gi < NSLOT; gi++) begin : g_src
        if (gi < NPORT) begin : g_net
            assign src_flit[gi] = in_flit[gi*FW +: FW];
            assign age_vec[gi]  = in_flit[gi*FW+PW +: AW];
        end else begin : g_inj
            assign src_flit[gi] = inj_flit;
        end
        defl_route_calc #(.CW(CW)) u_route (
            .here_x   (here_x),
            .here_y   (here_y),
            .dst_x    (src_flit[gi][FW-1 -: CW]),
            .dst_y    (src_flit[gi][FW-1-CW -: CW]),
            .want     (want[gi]),
            .is_local (loc[gi])
        );
    end

    defl_age_sort #(.AW(AW)) u_sort (
        .clk   (clk),
        .rst_n (rst_n),
        .vld   (in_vld),
        .age   (age_vec),
        .order (ord)
    );

    logic                      ej_hit;
    logic [IW-1:0]             ej_idx;
    int                        remain;
    logic [NSLOT-1:0]          s_vld;
    logic [NSLOT-1:0][IW-1:0]  s_want;
    logic [NSLOT-1:0]          s_pref;
    logic [NSLOT-1:0][FW-1:0]  s_src;
    logic [NSLOT-1:0][IW-1:0]  s_port;

    // ejection picks the first home-bound flit in age order
    always_comb begin
        ej_hit = 1'b0;
        ej_idx = '0;
        for (int k = 0; k < NPORT; k++) begin
            if (!ej_hit && in_vld[ord[k]] && loc[ord[k]]) begin
                ej_hit = 1'b1;
                ej_idx = ord[k];
            end
        end
        remain  = $countones(in_vld) - int'(ej_hit);
        inj_ack = inj_vld && (remain < NPORT);

        for (int k = 0; k < NPORT; k++) begin
            s_vld[k]  = in_vld[ord[k]] && !(ej_hit && ord[k] == ej_idx);
            s_want[k] = want[ord[k]];
            s_pref[k] = ~loc[ord[k]];
            s_src[k]  = src_flit[ord[k]];
        end
        s_vld[NPORT]  = inj_ack;
        s_want[NPORT] = want[NPORT];
        s_pref[NPORT] = ~loc[NPORT];
        s_src[NPORT]  = inj_flit;
    end

    defl_port_alloc u_alloc (
        .clk    (clk),
        .rst_n  (rst_n),
        .s_vld  (s_vld),
        .s_want (s_want),
        .s_pref (s_pref),
        .s_port (s_port)
    );

    always_comb begin
        d = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (s_vld[s]) begin
                d.ovld[s_port[s]]  = 1'b1;
                d.oflit[s_port[s]] = s_src[s];
            end
        end
        d.ejv = ej_hit;
        d.ejf = ej_hit ? src_flit[ej_idx] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_vld  = q.ovld;
    assign out_flit = q.oflit;
    assign ej_vld   = q.ejv;
    assign ej_flit  = q.ejf;

    // R5
    flow_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(q.ovld) + int'(q.ejv)) == $past($countones(in_vld) + int'(inj_ack)));
    // R6
    eject_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d.ejv |-> (d.ejf[FW-1 -: CW] == here_x && d.ejf[FW-1-CW -: CW] == here_y));
    // R7
    inject_req_chk: assert property (@(posedge clk) disable iff (!rst_n) inj_ack |-> inj_vld);
endmodule

// File: tb/defl_router_alloc_bench.sv
`timescale 1ns/1ps
module defl_router_alloc_bench;
    import defl_pkg::*;
    localparam int CW = 3;
    localparam int AW = 4;
    localparam int PW = 8;
    localparam int FW = 2 * CW + AW + PW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [CW-1:0]         here_x = 3'd3;
    logic [CW-1:0]         here_y = 3'd3;
    logic [NPORT-1:0]      in_vld = '0;
    logic [NPORT*FW-1:0]   in_flit = '0;
    logic                  inj_vld = 1'b0;
    logic [FW-1:0]         inj_flit = '0;
    logic                  inj_ack;
    logic [NPORT-1:0]      out_vld;
    logic [NPORT*FW-1:0]   out_flit;
    logic                  ej_vld;
    logic [FW-1:0]         ej_flit;

    defl_router_alloc #(.CW(CW), .AW(AW), .PW(PW)) u_defl_router_alloc (
        .clk(clk), .rst_n(rst_n), .here_x(here_x), .here_y(here_y),
        .in_vld(in_vld), .in_flit(in_flit), .inj_vld(inj_vld), .inj_flit(inj_flit),
        .inj_ack(inj_ack), .out_vld(out_vld), .out_flit(out_flit),
        .ej_vld(ej_vld), .ej_flit(ej_flit)
    );

    logic [3:0]    b_vld;
    logic [FW-1:0] b_fl [4];
    logic          b_iv;
    logic [FW-1:0] b_if;

    logic [3:0]    e_vld;
    logic [3:0]    e_prev;
    logic [FW-1:0] e_fl [4];
    logic          e_ejv;
    logic [FW-1:0] e_ejf;
    logic          e_ack;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    int unsigned seed = 32'h1234_5678;
    int pay = 0;

    function automatic logic [FW-1:0] mk(int dx, int dy, int ag, int pl);
        return {CW'(dx), CW'(dy), AW'(ag), PW'(pl)};
    endfunction

    function automatic int want_of(logic [FW-1:0] f);
        int dx = int'(f[FW-1 -: CW]);
        int dy = int'(f[FW-1-CW -: CW]);
        if (dx > int'(here_x)) return 2;
        if (dx < int'(here_x)) return 3;
        if (dy > int'(here_y)) return 0;
        if (dy < int'(here_y)) return 1;
        return -1;
    endfunction

    function automatic bit older(int i, int j);
        int ai = int'(b_fl[i][PW +: AW]);
        int aj = int'(b_fl[j][PW +: AW]);
        if (b_vld[i] != b_vld[j]) return b_vld[i];
        if (ai != aj) return ai < aj;
        return i < j;
    endfunction

    function automatic int unsigned rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed >> 8;
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference: selection sort by age, then greedy port hand-out
    task automatic model();
        int ord [4];
        bit used [4];
        int ejx = -1;
        int remain;
        logic [3:0] fr = 4'hF;
        for (int i = 0; i < 4; i++) used[i] = 1'b0;
        for (int r = 0; r < 4; r++) begin
            int best = -1;
            for (int i = 0; i < 4; i++)
                if (!used[i] && (best < 0 || older(i, best))) best = i;
            used[best] = 1'b1;
            ord[r] = best;
        end
        for (int r = 0; r < 4; r++)
            if (ejx < 0 && b_vld[ord[r]] && want_of(b_fl[ord[r]]) < 0) ejx = ord[r];
        e_ejv = (ejx >= 0);
        e_ejf = (ejx >= 0) ? b_fl[ejx] : '0;
        remain = $countones(b_vld) - ((ejx >= 0) ? 1 : 0);
        e_ack = b_iv && (remain < 4);
        e_vld = '0;
        for (int p = 0; p < 4; p++) e_fl[p] = '0;
        for (int r = 0; r < 5; r++) begin
            bit v;
            logic [FW-1:0] f;
            int w;
            int p;
            if (r < 4) begin
                v = b_vld[ord[r]] && (ord[r] != ejx);
                f = b_fl[ord[r]];
            end else begin
                v = e_ack;
                f = b_if;
            end
            if (v) begin
                w = want_of(f);
                p = -1;
                if (w >= 0 && fr[w]) p = w;
                else for (int j = 3; j >= 0; j--) if (fr[j]) p = j;
                fr[p] = 1'b0;
                e_vld[p] = 1'b1;
                e_fl[p] = f;
            end
        end
    endtask

    task automatic apply();
        @(negedge clk);
        in_vld = b_vld;
        for (int i = 0; i < 4; i++) in_flit[i*FW +: FW] = b_fl[i];
        inj_vld = b_iv;
        inj_flit = b_if;
        model();
        #1;
        check(inj_ack == e_ack, "R7 inj_ack", 64'(inj_ack), 64'(e_ack));
        check(out_vld == e_prev, "R8 out_vld before edge", 64'(out_vld), 64'(e_prev));
        @(posedge clk);
        #1;
        check(out_vld == e_vld, "R5 out_vld", 64'(out_vld), 64'(e_vld));
        for (int p = 0; p < 4; p++)
            if (e_vld[p])
                check(out_flit[p*FW +: FW] == e_fl[p], "R4 port flit",
                      64'(out_flit[p*FW +: FW]), 64'(e_fl[p]));
        check(ej_vld == e_ejv, "R6 ej_vld", 64'(ej_vld), 64'(e_ejv));
        if (e_ejv) check(ej_flit == e_ejf, "R6 ej_flit", 64'(ej_flit), 64'(e_ejf));
        e_prev = e_vld;
    endtask

    task automatic clear();
        b_vld = '0;
        b_iv = 1'b0;
        b_if = '0;
        for (int i = 0; i < 4; i++) b_fl[i] = '0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        clear();
        e_prev = '0;
        repeat (3) @(posedge clk);
        #1;
        check(out_vld == 4'b0 && ej_vld == 1'b0, "R1 reset outputs", 64'({out_vld, ej_vld}), 64'(0));
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(out_vld == 4'b0 && ej_vld == 1'b0, "R1 after release", 64'({out_vld, ej_vld}), 64'(0));

        // R2: single flit in each direction, X before Y
        clear(); b_vld = 4'b0010; b_fl[1] = mk(5, 3, 1, 8'h11); apply();
        check(out_vld == 4'b0100, "R2 east", 64'(out_vld), 64'(4'b0100));
        clear(); b_vld = 4'b0010; b_fl[1] = mk(1, 3, 1, 8'h12); apply();
        check(out_vld == 4'b1000, "R2 west", 64'(out_vld), 64'(4'b1000));
        clear(); b_vld = 4'b0010; b_fl[1] = mk(3, 6, 1, 8'h13); apply();
        check(out_vld == 4'b0001, "R2 north", 64'(out_vld), 64'(4'b0001));
        clear(); b_vld = 4'b0010; b_fl[1] = mk(3, 0, 1, 8'h14); apply();
        check(out_vld == 4'b0010, "R2 south", 64'(out_vld), 64'(4'b0010));
        clear(); b_vld = 4'b0010; b_fl[1] = mk(5, 6, 1, 8'h15); apply();
        check(out_vld == 4'b0100, "R2 x first", 64'(out_vld), 64'(4'b0100));

        // R3: all want east with equal ages, input 0 wins
        clear(); b_vld = 4'hF;
        for (int i = 0; i < 4; i++) b_fl[i] = mk(5, 3, 2, 8'hA0 + i);
        apply();
        check(out_flit[2*FW +: PW] == 8'hA0, "R3 tie east", 64'(out_flit[2*FW +: PW]), 64'(8'hA0));
        check(out_flit[0*FW +: PW] == 8'hA1, "R4 deflect north", 64'(out_flit[0*FW +: PW]), 64'(8'hA1));
        // R3: youngest index but oldest age wins
        b_fl[0] = mk(5, 3, 3, 8'hB0); b_fl[1] = mk(5, 3, 1, 8'hB1);
        b_fl[2] = mk(5, 3, 2, 8'hB2); b_fl[3] = mk(5, 3, 0, 8'hB3);
        apply();
        check(out_flit[2*FW +: PW] == 8'hB3, "R3 oldest east", 64'(out_flit[2*FW +: PW]), 64'(8'hB3));

        // R6/R7: four home flits, oldest ejected, room opens for injection
        clear(); b_vld = 4'hF;
        b_fl[0] = mk(3, 3, 2, 8'hC0); b_fl[1] = mk(3, 3, 1, 8'hC1);
        b_fl[2] = mk(3, 3, 3, 8'hC2); b_fl[3] = mk(3, 3, 1, 8'hC3);
        b_iv = 1'b1; b_if = mk(5, 3, 9, 8'hC4);
        apply();
        check(ej_flit[PW-1:0] == 8'hC1, "R6 oldest ejected", 64'(ej_flit[PW-1:0]), 64'(8'hC1));
        check(out_flit[3*FW +: PW] == 8'hC4, "R7 injected deflected west", 64'(out_flit[3*FW +: PW]), 64'(8'hC4));
        // R7: full load, no ejection, injection refused
        for (int i = 0; i < 4; i++) b_fl[i] = mk(1, 3, i, 8'hD0 + i);
        apply();
        check(inj_ack == 1'b0, "R7 refused when full", 64'(inj_ack), 64'(0));

        // sweep every valid mask and injection request with random flits
        for (int m = 0; m < 16; m++) begin
            for (int iv = 0; iv < 2; iv++) begin
                for (int rep = 0; rep < 40; rep++) begin
                    b_vld = 4'(m);
                    for (int i = 0; i < 4; i++) begin
                        pay++;
                        b_fl[i] = mk(2 + int'(rnd() % 3), 2 + int'(rnd() % 3), int'(rnd() % 4), pay);
                    end
                    b_iv = iv[0];
                    pay++;
                    b_if = mk(2 + int'(rnd() % 3), 2 + int'(rnd() % 3), int'(rnd() % 16), pay);
                    apply();
                end
            end
        end

        clear();
        apply();
        done = 1'b1;
        summary();
        $finish;
    end
endmodule